// File: doc/BRIEF.md
# Cache Tag Store with Match Comparator

A direct-mapped tag memory for a secondary cache. Every entry holds a tag word and three status bits: valid, dirty and write-through. The current address selects one entry. A comparator checks the stored tag against the incoming tag and raises `match` in the same cycle, so the cache controller can start a data access without waiting for a clock edge. Reads and compares are combinational from the address. Tag writes, status writes and the bulk invalidation take effect on the rising clock edge.

The block also forms a transfer acknowledge from the match result, the stored valid and write-through bits, the access direction and an external acknowledge input, so glue logic outside the tag store stays small. Two chip selects with opposite polarity allow depth expansion. A mode input picks between fixed status meanings, in which the valid bit gates the match, and generic user status bits, which do not gate it. The address width is a parameter: 14 bits gives the full 16K-entry array, and the default is kept smaller.

Top module: `cache_tag_store`

## Requirements
- R1: On a rising edge with the chip selected (`cs1_n` low and `cs2` high) and `tag_we_n` low, the entry at `addr` takes `tag_in` as its tag. Its status bits are left unchanged.
- R2: On a rising edge with the chip selected and `st_we_n` low, the entry at `addr` takes `st_in` as its status bits. Its tag is left unchanged. Status bit 0 is valid, bit 1 is dirty and bit 2 is write-through, both in `st_in` and in `st_out`.
- R3: With `generic_mode` low, `match` is 1 exactly when the chip is selected, the stored tag at `addr` equals `tag_in`, and the stored valid bit is 1.
- R4: With `generic_mode` high, `match` is 1 exactly when the chip is selected and the stored tag equals `tag_in`, whatever the stored valid bit holds.
- R5: When `rst_n` is low at a rising edge, the status bits of every entry become 0 and no tag changes. If a status write is requested at that same edge, the reset takes priority.
- R6: While the chip is deselected, no write happens, `match` is 0, and `tag_out`, `st_out`, `tag_out_en` and `st_out_en` are all 0.
- R7: `tag_out` shows the stored tag and `tag_out_en` is 1 when the chip is selected and `tag_oe_n` is low. Otherwise both are 0. `st_out` and `st_out_en` behave the same way under `st_oe_n`.
- R8: `xfer_ack` is 1 exactly when `ack_oe_n` is low, `ack_force` is low, and either `ext_ack` is 1 or (`match` is 1, the stored valid bit is 1, and either `rd_not_wr` is 1 or the stored write-through bit is 0).
- R9: Read data and `match` follow a change of `addr` or `tag_in` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes and status clear |
| rst_n | input | 1 | Synchronous clear of all status bits, active low |
| addr | input | ADDR_W | Entry index |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| tag_we_n | input | 1 | Tag write enable, active low |
| st_we_n | input | 1 | Status write enable, active low |
| tag_oe_n | input | 1 | Tag output enable, active low |
| st_oe_n | input | 1 | Status output enable, active low |
| ack_oe_n | input | 1 | Acknowledge output enable, active low |
| generic_mode | input | 1 | 1: status bits are generic and do not gate match |
| rd_not_wr | input | 1 | Access direction from the processor, 1 for read |
| ext_ack | input | 1 | External acknowledge request |
| ack_force | input | 1 | Forces the acknowledge to its deasserted level |
| tag_in | input | TAG_W | Tag to write and to compare |
| st_in | input | 3 | Status to write: {write-through, dirty, valid} |
| tag_out | output | TAG_W | Stored tag, or 0 when disabled |
| tag_out_en | output | 1 | Tag output is being driven |
| st_out | output | 3 | Stored status, or 0 when disabled |
| st_out_en | output | 1 | Status output is being driven |
| match | output | 1 | Stored tag equals `tag_in` (qualified) |
| xfer_ack | output | 1 | Transfer acknowledge, active high |

## Verification
The assertions assume that the address, tag and control inputs settle between clock edges and hold steady across each rising edge. They also assume that a tag can be trusted only after it has been written at least once. The write-visibility check applies only when the address and tag stay the same across the following edge. The bench drives every input just after the falling edge and writes every tag with reset high before it enables any tag output. Until then it keeps the chip deselected or the tag output off, so no undefined tag reaches a compared output.

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              tag_we_n,
  input  logic              st_we_n,
  input  logic              tag_oe_n,
  input  logic              st_oe_n,
  input  logic              ack_oe_n,
  input  logic              generic_mode,
  input  logic              rd_not_wr,
  input  logic              ext_ack,
  input  logic              ack_force,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [2:0]        st_in,
  output logic [TAG_W-1:0]  tag_out,
  output logic              tag_out_en,
  output logic [2:0]        st_out,
  output logic              st_out_en,
  output logic              match,
  output logic              xfer_ack
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [DEPTH-1:0] vld_q, dty_q, wt_q;
  logic             sel, cur_vld, cur_dty, cur_wt, tag_eq;
  logic [TAG_W-1:0] cur_tag;

  assign sel     = ~cs1_n & cs2;
  assign cur_tag = tag_mem[addr];
  assign cur_vld = vld_q[addr];
  assign cur_dty = dty_q[addr];
  assign cur_wt  = wt_q[addr];
  assign tag_eq  = (cur_tag == tag_in);

  always_ff @(posedge clk) begin
    if (sel && !tag_we_n) tag_mem[addr] <= tag_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
      wt_q  <= '0;
    end else if (sel && !st_we_n) begin
      vld_q[addr] <= st_in[0];
      dty_q[addr] <= st_in[1];
      wt_q[addr]  <= st_in[2];
    end
  end

  assign match      = sel & tag_eq & (generic_mode | cur_vld);
  assign tag_out_en = sel & ~tag_oe_n;
  assign st_out_en  = sel & ~st_oe_n;
  assign tag_out    = tag_out_en ? cur_tag : '0;
  assign st_out     = st_out_en ? {cur_wt, cur_dty, cur_vld} : 3'b000;
  assign xfer_ack   = ~ack_oe_n & ~ack_force &
                      (ext_ack | (match & cur_vld & (rd_not_wr | ~cur_wt)));

  logic clr_seen;
  always_ff @(posedge clk) clr_seen <= ~rst_n;

  a_r1_tag_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !tag_we_n) |=> (!($stable(addr) && $stable(tag_in)) || cur_tag == tag_in));

  a_r2_tag_hold_without_we: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel || tag_we_n) |=> (!$stable(addr) || cur_tag == $past(cur_tag)));

  a_r3_match_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!generic_mode && match) |-> cur_vld);

  a_r5_bulk_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_seen |-> ((vld_q | dty_q | wt_q) == '0));

  a_r6_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!match && tag_out == '0 && st_out == 3'b000));

  a_r8_force_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_force || ack_oe_n) |-> !xfer_ack);

  a_r8_ext_ack_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ack && !ack_oe_n && !ack_force) |-> xfer_ack);
endmodule

// File: tb/cache_tag_store_tb_top.sv
module cache_tag_store_tb_top;
  localparam int AW = 8;
  localparam int TW = 12;
  localparam int N  = 1 << AW;

  logic clk = 0;
  logic rst_n, cs1_n, cs2, tag_we_n, st_we_n, tag_oe_n, st_oe_n, ack_oe_n;
  logic generic_mode, rd_not_wr, ext_ack, ack_force;
  logic [AW-1:0] addr;
  logic [TW-1:0] tag_in, tag_out;
  logic [2:0] st_in, st_out;
  logic tag_out_en, st_out_en, match, xfer_ack;

  cache_tag_store #(.ADDR_W(AW), .TAG_W(TW)) dut_i (.*);

  always #5 clk = ~clk;

  logic [TW-1:0] m_tag [N];
  logic [2:0]    m_st  [N];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic compare_all(string req);
    logic s, m, a;
    logic [2:0] st;
    s  = !cs1_n && cs2;
    st = m_st[addr];
    m  = s && (m_tag[addr] == tag_in) && (generic_mode || st[0]);
    a  = !ack_oe_n && !ack_force && (ext_ack || (m && st[0] && (rd_not_wr || !st[2])));
    chk(req, "match", 32'(match), 32'(m));
    chk(req, "tag_out_en", 32'(tag_out_en), 32'(s && !tag_oe_n));
    chk(req, "tag_out", 32'(tag_out), (s && !tag_oe_n) ? 32'(m_tag[addr]) : 32'd0);
    chk(req, "st_out_en", 32'(st_out_en), 32'(s && !st_oe_n));
    chk(req, "st_out", 32'(st_out), (s && !st_oe_n) ? 32'(st) : 32'd0);
    chk(req, "xfer_ack", 32'(xfer_ack), 32'(a));
  endtask

  // inputs are driven after a falling edge; compare, then update model at the rising edge
  task automatic cycle(string req);
    #1 compare_all(req);
    @(posedge clk);
    if (!cs1_n && cs2 && !tag_we_n) m_tag[addr] = tag_in;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_st[i] = 3'b000;
    end else if (!cs1_n && cs2 && !st_we_n) m_st[addr] = st_in;
    @(negedge clk);
  endtask

  task automatic idle();
    rst_n = 1; cs1_n = 0; cs2 = 1; tag_we_n = 1; st_we_n = 1;
    tag_oe_n = 0; st_oe_n = 0; ack_oe_n = 0; generic_mode = 0;
    rd_not_wr = 1; ext_ack = 0; ack_force = 0; st_in = 0;
  endtask

  task automatic rd(string req, int a, logic [TW-1:0] t);
    idle(); addr = AW'(a); tag_in = t; cycle(req);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(); addr = 0; tag_in = 0; cs2 = 0; rst_n = 0;
    @(negedge clk);
    cycle("R5"); cycle("R5");
    // R1: fill every tag with outputs off
    for (int a = 0; a < N; a++) begin
      idle(); tag_oe_n = 1; addr = AW'(a); tag_in = TW'(a * 37 + 5); tag_we_n = 0;
      cycle("R1");
    end
    // R5 reset state: all status zero, match gated
    for (int a = 0; a < 8; a++) rd("R5", a, TW'(a * 37 + 5));
    // R2: status write keeps tag
    for (int a = 0; a < 8; a++) begin
      idle(); addr = AW'(a); tag_in = 0; st_we_n = 0; st_in = 3'(a); cycle("R2");
      rd("R2", a, TW'(a * 37 + 5));
    end
    // R1: tag write keeps status
    idle(); addr = 5; tag_in = 12'hABC; tag_we_n = 0; cycle("R1");
    rd("R1", 5, 12'hABC);
    // R3 dedicated mode: hit, miss, invalid
    rd("R3", 1, TW'(1 * 37 + 5));
    rd("R3", 1, 12'h000);
    rd("R3", 2, TW'(2 * 37 + 5));
    // R4 generic mode: invalid entry still matches
    idle(); generic_mode = 1; addr = 2; tag_in = TW'(2 * 37 + 5); cycle("R4");
    idle(); generic_mode = 1; addr = 2; tag_in = 12'h001; cycle("R4");
    // R6 deselected writes ignored, outputs quiet
    idle(); cs1_n = 1; addr = 3; tag_in = 12'h111; tag_we_n = 0; st_we_n = 0; st_in = 3'b111; cycle("R6");
    idle(); cs2 = 0; addr = 3; tag_in = 12'h222; tag_we_n = 0; st_we_n = 0; st_in = 3'b111; cycle("R6");
    rd("R6", 3, TW'(3 * 37 + 5));
    // R7 output enables
    idle(); tag_oe_n = 1; addr = 7; tag_in = 0; cycle("R7");
    idle(); st_oe_n = 1; addr = 7; tag_in = 0; cycle("R7");
    // R8 acknowledge combinations on entry 7 (valid + dirty + wt) and entry 1 (valid only)
    for (int k = 0; k < 32; k++) begin
      idle(); addr = (k & 16) ? 7 : 1; tag_in = (k & 16) ? TW'(7 * 37 + 5) : TW'(1 * 37 + 5);
      rd_not_wr = k[0]; ext_ack = k[1]; ack_force = k[2]; ack_oe_n = k[3];
      cycle("R8");
    end
    // R5 clear during status write; tags intact
    idle(); rst_n = 0; addr = 6; st_we_n = 0; st_in = 3'b111; tag_in = 0; cycle("R5");
    for (int a = 0; a < 8; a++) rd("R5", a, a == 5 ? 12'hABC : TW'(a * 37 + 5));
    // R9 combinational read: change address without a clock edge
    idle(); addr = 4; tag_in = TW'(4 * 37 + 5); st_we_n = 0; st_in = 3'b001; cycle("R9");
    idle(); addr = 4; tag_in = TW'(4 * 37 + 5);
    #1 compare_all("R9");
    #2 addr = 3; tag_in = TW'(3 * 37 + 5);
    #1 compare_all("R9");
    #2 addr = 4;
    #1 compare_all("R9");
    @(negedge clk);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, 15));
      idle(); addr = a;
      tag_in = ($urandom_range(0, 3) == 0) ? TW'($urandom) : m_tag[a];
      rst_n = ($urandom_range(0, 60) != 0);
      cs1_n = ($urandom_range(0, 7) == 0); cs2 = ($urandom_range(0, 7) != 0);
      tag_we_n = ($urandom_range(0, 5) != 0); st_we_n = ($urandom_range(0, 3) != 0);
      st_in = 3'($urandom); tag_oe_n = ($urandom_range(0, 4) == 0);
      st_oe_n = ($urandom_range(0, 4) == 0); ack_oe_n = ($urandom_range(0, 4) == 0);
      generic_mode = ($urandom_range(0, 3) == 0); rd_not_wr = 1'($urandom);
      ext_ack = ($urandom_range(0, 5) == 0); ack_force = ($urandom_range(0, 7) == 0);
      cycle("R3");
    end
    finish_run();
  end
endmodule